// File: doc/BRIEF.md
# Inertial Sensor Bring-Up and Polling Controller

This block is the host-side controller for a combined rate and acceleration sensor that is reached over a 32-bit full-duplex serial link. After reset it waits until the sensor accepts traffic and writes the chosen output filter. It then waits out the start-up time for that filter, counted from reset. Next it reads each diagnostic status register once, which clears the flags the sensor latched while it started. It collects the last of those answers with one extra read, and from then on it polls the data registers in a fixed round.

The serial link answers every frame with the result of the frame before it. The controller keeps a tag for the request still in flight. It uses that tag to check each answer and to route it to the right place. Each request is a stream item on a valid/ready port toward a separate shifter, and each answer comes back on a second valid/ready port. The controller has one frame in flight at a time. It raises `req_valid` only after the previous answer has been taken, and it holds `rsp_ready` high only while it waits for that answer. Checked data words leave on a third valid/ready stream. While a word waits for `sample_ready`, the word stays stable and no new frame is requested, so back-pressure on the sample stream pauses the serial link.

Frame layout, most significant bit first: bit 31 is write (1) or read (0), bits 30:26 are the register address, bits 25:24 are the return status (zero in requests), bits 23:8 are the 16-bit data, and bits 7:0 are the checksum over bits 31:8.

Top module: `sensor_bringup`

## Requirements
- R1: No request is offered before BOOT_MS·CLK_KHZ clock cycles have passed since reset was released.
- R2: The first request writes address 1Fh with data 2000h (frame FC200006h) when `filt_10hz` is 0 at the end of the boot wait, and with data 1000h (frame FC1000C7h) when it is 1.
- R3: No request after the filter write is offered before T60_MS·CLK_KHZ cycles since reset (60 Hz filter) or T10_MS·CLK_KHZ cycles (10 Hz filter).
- R4: The clearing pass reads 09h, 0Ah, 0Fh, 1Bh and 1Fh in that order (frames 240000C7h, 280000CDh, 3C0000D3h, 6C0000ABh, 7C0000B3h), followed by one extra read of 1Fh (7C0000B3h).
- R5: After the clearing pass, reads of 01h, 04h, 05h, 06h and 07h repeat in that order without end (frames 040000F7h, 100000E9h, 140000EFh, 180000E5h, 1C0000E3h), and `polling` is high from then on.
- R6: Each answer is credited to the request sent before it. The answer to the very first request is never checked. Only answers to data reads become samples, tagged with the address that was read.
- R7: The checksum is CRC-8 with polynomial 1Dh, start value FFh and the result inverted, taken over bits 31:8. A mismatch on any checked answer sets `crc_err`, which stays high until reset, and that answer is dropped.
- R8: A data answer whose bits 25:24 are not 01b is dropped and sets `rs_err`, which stays high until reset.
- R9: If the answer to the 1Bh read has data bit 6 (frame bit 14) at 0, `restart_req` goes high and stays high, and no further request is offered.
- R10: While `sample_valid` is high and `sample_ready` is low, the sample address and data stay stable and no request is offered. At most one of `req_valid` and `rsp_ready` is high in any cycle.
- R11: While reset is held, `req_valid`, `sample_valid`, `polling`, `crc_err`, `rs_err` and `restart_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| filt_10hz | input | 1 | Filter choice, 1 selects 10 Hz, sampled when the boot wait ends |
| req_valid | output | 1 | Request frame offered to the shifter |
| req_ready | input | 1 | Shifter accepts the request |
| req_frame | output | 32 | Request frame |
| rsp_valid | input | 1 | Answer frame from the shifter |
| rsp_ready | output | 1 | Controller waits for an answer |
| rsp_frame | input | 32 | Answer frame |
| sample_valid | output | 1 | Checked data word offered |
| sample_ready | input | 1 | Consumer accepts the data word |
| sample_addr | output | 5 | Register the word came from |
| sample_data | output | 16 | Data word |
| polling | output | 1 | Clearing pass done, cyclic polling active |
| crc_err | output | 1 | Sticky checksum mismatch |
| rs_err | output | 1 | Sticky bad return status on data |
| restart_req | output | 1 | Sticky request to reset the sensor |

## Verification
The first run selects the 60 Hz filter and answers with correct frames. It then corrupts one data checksum and later returns one bad status. This shows that each fault sets only its own flag and removes only its own sample, and that the undefined first answer is never checked. The second run selects the 10 Hz filter and returns a failed loop-filter bit. This shows the longer start-up wait, the other filter frame, and the halt together with the restart request. Throughout both runs, the consumer accepts samples on an irregular pattern, which tests that a held sample stays stable and that the serial link stalls behind it.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef logic [4:0] addr_t;

  typedef enum logic [1:0] {TAG_NONE, TAG_ACK, TAG_STAT, TAG_DATA} tag_t;
  typedef enum logic [1:0] {PH_FILT, PH_CLEAR, PH_POLL} phase_t;
  typedef enum logic [2:0] {ST_BOOT, ST_REQ, ST_RSP, ST_SWAIT, ST_SMP, ST_HALT} state_t;

  localparam addr_t       ADDR_SUMMARY = 5'h1F;
  localparam addr_t       ADDR_COMMON  = 5'h1B;
  localparam int          LOOP_BIT     = 6;
  localparam logic [1:0]  RS_NORMAL    = 2'b01;
  localparam logic [15:0] FLT_60HZ     = 16'h2000;
  localparam logic [15:0] FLT_10HZ     = 16'h1000;
  localparam logic [2:0]  CLEAR_LAST   = 3'd5;  // index of the extra read
  localparam logic [2:0]  POLL_LAST    = 3'd4;

  function automatic logic [7:0] crc8_24(input logic [23:0] body);
    logic [7:0] r;
    logic       fb;
    r = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      fb = r[7] ^ body[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h1D;
    end
    return ~r;
  endfunction

  function automatic addr_t clear_addr(input logic [2:0] i);
    case (i)
      3'd0:    return 5'h09;
      3'd1:    return 5'h0A;
      3'd2:    return 5'h0F;
      3'd3:    return 5'h1B;
      default: return 5'h1F;
    endcase
  endfunction

  function automatic addr_t poll_addr(input logic [2:0] i);
    case (i)
      3'd0:    return 5'h01;
      3'd1:    return 5'h04;
      3'd2:    return 5'h05;
      3'd3:    return 5'h06;
      default: return 5'h07;
    endcase
  endfunction
endpackage

// File: rtl/sbu_timer.sv
module sbu_timer #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned BOOT_MS = 20,
  parameter int unsigned T60_MS  = 620,
  parameter int unsigned T10_MS  = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic boot_done,
  output logic start_done
);
  localparam int unsigned BOOT_CYC = CLK_KHZ * BOOT_MS;
  localparam int unsigned T60_CYC  = CLK_KHZ * T60_MS;
  localparam int unsigned T10_CYC  = CLK_KHZ * T10_MS;
  localparam int unsigned MAX_A    = (T60_CYC > T10_CYC) ? T60_CYC : T10_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > BOOT_CYC) ? MAX_A : BOOT_CYC;
  localparam int          CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] BOOT_C = CW'(BOOT_CYC);
  localparam logic [CW-1:0] T60_C  = CW'(T60_CYC);
  localparam logic [CW-1:0] T10_C  = CW'(T10_CYC);
  localparam logic [CW-1:0] MAX_C  = CW'(MAX_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt != MAX_C)  cnt <= cnt + 1'b1;
  end

  assign boot_done  = (cnt >= BOOT_C);
  assign start_done = (cnt >= (slow_sel ? T10_C : T60_C));

  assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX_C) |=> (cnt == MAX_C));
endmodule

// File: rtl/sbu_framer.sv
module sbu_framer import sbu_pkg::*; (
  input  logic        wr,
  input  addr_t       addr,
  input  logic [15:0] wdata,
  output logic [31:0] frame
);
  logic [23:0] body;
  assign body  = {wr, addr, 2'b00, wdata};
  assign frame = {body, crc8_24(body)};
endmodule

// File: rtl/sbu_rsp_split.sv
module sbu_rsp_split import sbu_pkg::*; (
  input  logic [31:0] frame,
  output logic        crc_ok,
  output logic [1:0]  rs,
  output logic [15:0] data
);
  assign crc_ok = (crc8_24(frame[31:8]) == frame[7:0]);
  assign rs     = frame[25:24];
  assign data   = frame[23:8];
endmodule

// File: rtl/sensor_bringup.sv
module sensor_bringup import sbu_pkg::*; #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned BOOT_MS = 20,
  parameter int unsigned T60_MS  = 620,
  parameter int unsigned T10_MS  = 750
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        filt_10hz,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_frame,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_frame,
  output logic        sample_valid,
  input  logic        sample_ready,
  output logic [4:0]  sample_addr,
  output logic [15:0] sample_data,
  output logic        polling,
  output logic        crc_err,
  output logic        rs_err,
  output logic        restart_req
);
  state_t      state;
  phase_t      phase;
  logic [2:0]  idx;
  logic        slow_q;
  tag_t        prev_tag, cur_tag;
  addr_t       prev_addr, cur_addr;
  logic        cur_wr;
  logic [15:0] cur_wdata;
  logic        boot_done, start_done;
  logic        r_crc_ok;
  logic [1:0]  r_rs;
  logic [15:0] r_data;
  logic        bad_crc, loop_fail, take, rs_bad;

  sbu_timer #(.CLK_KHZ(CLK_KHZ), .BOOT_MS(BOOT_MS), .T60_MS(T60_MS), .T10_MS(T10_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .slow_sel(slow_q), .boot_done(boot_done), .start_done(start_done));

  sbu_framer u_framer (.wr(cur_wr), .addr(cur_addr), .wdata(cur_wdata), .frame(req_frame));

  sbu_rsp_split u_split (.frame(rsp_frame), .crc_ok(r_crc_ok), .rs(r_rs), .data(r_data));

  // request selected by phase and position
  always_comb begin
    cur_wr    = 1'b0;
    cur_addr  = ADDR_SUMMARY;
    cur_wdata = '0;
    cur_tag   = TAG_ACK;
    case (phase)
      PH_FILT: begin
        cur_wr    = 1'b1;
        cur_wdata = slow_q ? FLT_10HZ : FLT_60HZ;
      end
      PH_CLEAR: if (idx != CLEAR_LAST) begin
        cur_addr = clear_addr(idx);
        cur_tag  = TAG_STAT;
      end
      default: begin
        cur_addr = poll_addr(idx);
        cur_tag  = TAG_DATA;
      end
    endcase
  end

  // answer judged against the tag of the request before it
  always_comb begin
    bad_crc   = (prev_tag != TAG_NONE) && !r_crc_ok;
    loop_fail = (prev_tag == TAG_STAT) && r_crc_ok && (prev_addr == ADDR_COMMON) && !r_data[LOOP_BIT];
    take      = (prev_tag == TAG_DATA) && r_crc_ok && (r_rs == RS_NORMAL);
    rs_bad    = (prev_tag == TAG_DATA) && r_crc_ok && (r_rs != RS_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_BOOT;
      phase       <= PH_FILT;
      idx         <= '0;
      slow_q      <= 1'b0;
      prev_tag    <= TAG_NONE;
      prev_addr   <= '0;
      sample_addr <= '0;
      sample_data <= '0;
      crc_err     <= 1'b0;
      rs_err      <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      case (state)
        ST_BOOT: if (boot_done) begin
          slow_q <= filt_10hz;
          state  <= ST_REQ;
        end
        ST_REQ: if (req_ready) state <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          prev_tag  <= cur_tag;
          prev_addr <= cur_addr;
          if (bad_crc) crc_err <= 1'b1;
          if (rs_bad)  rs_err  <= 1'b1;
          if (take) begin
            sample_addr <= prev_addr;
            sample_data <= r_data;
          end
          case (phase)
            PH_FILT:  phase <= PH_CLEAR;
            PH_CLEAR: if (idx == CLEAR_LAST) begin
              phase <= PH_POLL;
              idx   <= '0;
            end else idx <= idx + 3'd1;
            default:  idx <= (idx == POLL_LAST) ? 3'd0 : idx + 3'd1;
          endcase
          if (loop_fail) begin
            restart_req <= 1'b1;
            state       <= ST_HALT;
          end else if (take)              state <= ST_SMP;
          else if (phase == PH_FILT)      state <= ST_SWAIT;
          else                            state <= ST_REQ;
        end
        ST_SWAIT: if (start_done)   state <= ST_REQ;
        ST_SMP:   if (sample_ready) state <= ST_REQ;
        default: ;
      endcase
    end
  end

  assign req_valid    = (state == ST_REQ);
  assign rsp_ready    = (state == ST_RSP);
  assign sample_valid = (state == ST_SMP);
  assign polling      = (phase == PH_POLL);

  assert_no_early_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> boot_done);
  assert_start_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && phase != PH_FILT) |-> start_done);
  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_frame)));
  assert_sample_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !sample_ready) |=> (sample_valid && $stable(sample_addr) && $stable(sample_data) && !req_valid));
  assert_crc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> crc_err);
  assert_rs_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_err |=> rs_err);
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!req_valid && $past(restart_req || !req_valid)));
endmodule

// File: tb/sim_sensor_bringup.sv
`timescale 1ns/1ps
module sim_sensor_bringup;
  localparam int CK = 1, BM = 20, M60 = 620, M10 = 750;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, filt_10hz = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_frame;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_frame = '0;
  logic        sample_valid, sample_ready = 1'b0;
  logic [4:0]  sample_addr;
  logic [15:0] sample_data;
  logic        polling, crc_err, rs_err, restart_req;

  sensor_bringup #(.CLK_KHZ(CK), .BOOT_MS(BM), .T60_MS(M60), .T10_MS(M10)) u0 (
    .clk(clk), .rst_n(rst_n), .filt_10hz(filt_10hz),
    .req_valid(req_valid), .req_ready(req_ready), .req_frame(req_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .sample_valid(sample_valid), .sample_ready(sample_ready),
    .sample_addr(sample_addr), .sample_data(sample_data),
    .polling(polling), .crc_err(crc_err), .rs_err(rs_err), .restart_req(restart_req));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_req[$];
  logic [20:0] exp_smp[$];
  logic [31:0] last_req;
  logic [15:0] stat1b = 16'h0040;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [23:0] b);
    logic [7:0] c = 8'hFF;
    for (int i = 23; i >= 0; i--)
      c = (c[7] ^ b[i]) ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
    return ~c;
  endfunction

  // sensor model: take one request, answer with the previous one's result
  task automatic serve(input int k, input bit bad, input logic [1:0] rs, output int t_req);
    logic [31:0] f, e, resp;
    logic [15:0] d;
    logic [23:0] body;
    while (!req_valid) @(negedge clk);
    t_req = cyc;
    f = req_frame;
    e = (exp_req.size() > 0) ? exp_req.pop_front() : 32'h0;
    chk(f == e, "R4/R5 request frame", f, e);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    if (k == 0) resp = 32'hDEADBEEF;
    else begin
      if (last_req[31])                   d = last_req[23:8];
      else if (last_req[30:26] == 5'h1B)  d = stat1b;
      else                                d = 16'h0100 + 16'(k);
      body = {last_req[31:26], rs, d};
      resp = {body, bcrc(body) ^ (bad ? 8'h5A : 8'h00)};
      if (k >= 8 && !bad && rs == 2'b01) exp_smp.push_back({last_req[30:26], d});
    end
    last_req  = f;
    rsp_frame = resp;
    rsp_valid = 1'b1;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    @(negedge clk);
  endtask

  // sample consumer with irregular acceptance
  int pat = 0;
  initial forever begin
    @(posedge clk); #1;
    pat++;
    sample_ready = (pat % 3) != 0 && (pat % 7) != 2;
  end

  // monitor: compare samples with the scoreboard, watch holding
  logic        held = 1'b0;
  logic [20:0] held_v;
  always @(negedge clk) begin
    if (!rst_n) held = 1'b0;
    else if (sample_valid) begin
      if (held) chk({sample_addr, sample_data} == held_v, "R10 sample held stable", {11'd0, sample_addr, sample_data}, {11'd0, held_v});
      if (held) chk(!req_valid, "R10 no request while sample waits", {31'd0, req_valid}, 32'd0);
      if (sample_ready) begin
        logic [20:0] x;
        x = (exp_smp.size() > 0) ? exp_smp.pop_front() : 21'h1FFFFF;
        chk({sample_addr, sample_data} == x, "R6 sample address and data", {11'd0, sample_addr, sample_data}, {11'd0, x});
        held = 1'b0;
      end else begin
        held   = 1'b1;
        held_v = {sample_addr, sample_data};
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    logic [31:0] polls[5] = '{32'h040000F7, 32'h100000E9, 32'h140000EF, 32'h180000E5, 32'h1C0000E3};
    logic [31:0] clr[5]   = '{32'h240000C7, 32'h280000CD, 32'h3C0000D3, 32'h6C0000AB, 32'h7C0000B3};
    bit saw;

    // R11 reset state
    repeat (4) @(negedge clk);
    chk({req_valid, sample_valid, polling, crc_err, rs_err, restart_req} == 6'b0, "R11 reset outputs",
        {26'd0, req_valid, sample_valid, polling, crc_err, rs_err, restart_req}, 32'd0);

    // run 1: 60 Hz, checksum and status faults injected
    exp_req.push_back(32'hFC200006);
    foreach (clr[i]) exp_req.push_back(clr[i]);
    exp_req.push_back(32'h7C0000B3);
    for (int r = 0; r < 3; r++) foreach (polls[i]) exp_req.push_back(polls[i]);
    filt_10hz = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 22; k++) begin
      serve(k, k == 12, (k == 15) ? 2'b11 : 2'b01, t);
      if (k == 0) chk(t >= BM*CK && t <= BM*CK + 4, "R1 first request time", t, BM*CK);
      if (k == 1) chk(t >= M60*CK && t <= M60*CK + 6, "R3 start wait 60 Hz", t, M60*CK);
      if (k == 5) chk(!polling, "R5 polling low in clearing pass", {31'd0, polling}, 32'd0);
      if (k == 6) chk(polling, "R5 polling after extra read", {31'd0, polling}, 32'd1);
      if (k == 11) chk(!crc_err, "R7 no error yet, first answer unchecked", {31'd0, crc_err}, 32'd0);
      if (k == 12) chk(crc_err, "R7 checksum mismatch flagged", {31'd0, crc_err}, 32'd1);
      if (k == 14) chk(!rs_err, "R8 status clean so far", {31'd0, rs_err}, 32'd0);
      if (k == 15) chk(rs_err, "R8 bad status flagged", {31'd0, rs_err}, 32'd1);
    end
    repeat (30) @(negedge clk);
    chk(exp_smp.size() == 0, "R6 all expected samples delivered", exp_smp.size(), 0);
    chk(!restart_req && crc_err && rs_err, "R9 no restart with loop bit set",
        {29'd0, restart_req, crc_err, rs_err}, 32'd3);

    // run 2: 10 Hz, loop-filter bit failed
    rst_n = 1'b0; filt_10hz = 1'b1; stat1b = 16'hFFBF;
    exp_req.delete(); exp_smp.delete();
    repeat (3) @(negedge clk);
    chk({crc_err, rs_err, restart_req, polling} == 4'b0, "R11 flags cleared by reset",
        {28'd0, crc_err, rs_err, restart_req, polling}, 32'd0);
    exp_req.push_back(32'hFC1000C7);
    foreach (clr[i]) exp_req.push_back(clr[i]);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      serve(k, 1'b0, 2'b01, t);
      if (k == 1) chk(t >= M10*CK && t <= M10*CK + 6, "R3 start wait 10 Hz", t, M10*CK);
    end
    chk(restart_req, "R9 restart raised", {31'd0, restart_req}, 32'd1);
    saw = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (req_valid) saw = 1'b1;
    end
    chk(!saw && restart_req, "R9 halted after restart", {30'd0, saw, restart_req}, 32'd1);
    chk(exp_req.size() == 0, "R2 R4 all requests seen", exp_req.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule